// File: doc/BRIEF.md
# Configurable Funnel Shift Unit

This block joins two 32-bit words into one 64-bit pair and shifts the pair left or right. The low word sits in bits 31:0 and the high word in bits 63:32. It returns a single 32-bit half of the shifted pair: the upper half after a left shift and the lower half after a right shift. Chaining the halves this way lets wide shifts and rotates be built from word-sized steps. The shift amount comes either from a full 32-bit register operand or from a zero-extended immediate.

A 2-bit limit mode sets the largest amount the shift can apply. The same mode decides whether a right shift is logical or arithmetic. A wrap select decides how an oversized amount is reduced: it is either masked to the operand width or saturated at the limit. Two kinds of encoding are not supported: a nonzero extended-mode field and the reserved limit mode. Either one raises an illegal flag and forces the result to zero. It does not produce a shifted value.

The shifter itself is combinational. An output stage, chosen by parameter, is either a register with a valid strobe one cycle behind the input valid (the default) or a plain pass-through. There is no state machine. The only sequential state is the output register, which holds its contents until the next accepted input.

Top module: `funnel_shift_unit`

## Requirements
- R1: With an effective shift of zero, a left shift returns hi_word unchanged and a right shift returns lo_word unchanged.
- R2: With wrap_en low, the effective amount is the unsigned minimum of the requested amount and the limit. The limit is 32 when max_mode is 0 and 63 when max_mode is 2 or 3.
- R3: With wrap_en high, the effective amount is the requested amount masked to its low 5 bits when max_mode is 0, and to its low 6 bits when max_mode is 2 or 3.
- R4: When dir_right is 0, the shift is a logical left shift of {hi_word, lo_word} by the effective amount, and the result is bits 63:32 of the shifted value.
- R5: When dir_right is 1 and max_mode is 0 or 2, the shift is a logical right shift of {hi_word, lo_word} with zeros entering at bit 63, and the result is bits 31:0.
- R6: When dir_right is 1 and max_mode is 3, the shift is arithmetic, with bit 63 (hi_word bit 31) copied into the vacated bits, and the result is bits 31:0.
- R7: A nonzero ext_mode sets illegal to 1 and forces result to zero.
- R8: max_mode equal to 1 (reserved) sets illegal to 1 and forces result to zero. A legal operation leaves illegal at 0.
- R9: With the registered stage, out_valid is in_valid delayed by one clock. result and illegal then belong to the input accepted on that edge. All three outputs are zero after reset. While in_valid is low, result and illegal hold their values.
- R10: When use_imm is 1, the requested amount is amt_imm zero-extended to 32 bits. Otherwise it is amt_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the inputs |
| lo_word | input | 32 | Low word of the pair (bits 31:0) |
| hi_word | input | 32 | High word of the pair (bits 63:32) |
| amt_reg | input | 32 | Shift amount from a register |
| amt_imm | input | 20 | Shift amount from an immediate |
| use_imm | input | 1 | 1 selects amt_imm, 0 selects amt_reg |
| dir_right | input | 1 | 1 shifts right, 0 shifts left |
| max_mode | input | 2 | 0 = 32 limit, 1 = reserved, 2 = 64 unsigned, 3 = 64 signed |
| wrap_en | input | 1 | 1 masks the amount, 0 saturates it |
| ext_mode | input | 2 | Extended mode; must be zero |
| out_valid | output | 1 | Result valid strobe |
| result | output | 32 | Selected half of the shifted pair |
| illegal | output | 1 | Unsupported encoding seen |

## Verification
Two features can act on the same operation. Amount reduction, by clamp or mask, can coincide with arithmetic fill: a right shift in the signed 64-bit mode with an oversized request must saturate at 63 and give a word made only of sign bits. With wrap, the same request must wrap to a small shift. Illegal detection can also coincide with a shift that would otherwise give a nonzero value, and there the zero result must win. Directed vectors build each of these pairings on purpose. Seeded random vectors mix modes, directions, amount sources and encodings freely, and every registered output is compared against a bench model written from the requirements.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    typedef enum logic [1:0] {
        LIM_W32  = 2'd0,
        LIM_RSVD = 2'd1,
        LIM_W64U = 2'd2,
        LIM_W64S = 2'd3
    } lim_mode_e;
endpackage

// File: rtl/fsh_amount.sv
module fsh_amount
    import fsh_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 20,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int SH_W   = $clog2(PAIR_W)
) (
    input  logic [WORD_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic              use_imm,
    input  lim_mode_e         mode,
    input  logic              wrap_en,
    output logic [SH_W-1:0]   eff
);
    localparam logic [SH_W-1:0] LIM_NARROW = SH_W'(WORD_W);
    localparam logic [SH_W-1:0] LIM_WIDE   = SH_W'(PAIR_W - 1);

    logic [WORD_W-1:0] raw;
    logic [SH_W-1:0]   lim;
    logic              over;

    // R10: amount source
    assign raw = use_imm ? {{(WORD_W-IMM_W){1'b0}}, amt_imm} : amt_reg;
    assign lim = (mode == LIM_W32) ? LIM_NARROW : LIM_WIDE;
    assign over = (|raw[WORD_W-1:SH_W]) || (raw[SH_W-1:0] >= lim);

    always_comb begin
        if (wrap_en) begin
            // R3: mask to operand width
            if (mode == LIM_W32) eff = {1'b0, raw[SH_W-2:0]};
            else                 eff = raw[SH_W-1:0];
        end else begin
            // R2: saturate at the limit
            eff = over ? lim : raw[SH_W-1:0];
        end
    end
endmodule

// File: rtl/fsh_core.sv
module fsh_core #(
    parameter int WORD_W = 32,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int SH_W   = $clog2(PAIR_W),
    localparam int EXT_W  = PAIR_W + WORD_W
) (
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [SH_W-1:0]   eff,
    input  logic              dir_right,
    input  logic              arith,
    output logic [WORD_W-1:0] res
);
    logic [EXT_W-1:0]  win_l;
    logic [EXT_W-1:0]  win_r;
    logic [WORD_W-1:0] fill;
    logic [WORD_W-1:0] res_l;
    logic [WORD_W-1:0] res_r;
    int                top_l;

    // R6: sign fill only for the signed 64-bit mode
    assign fill  = arith ? {WORD_W{hi_word[WORD_W-1]}} : '0;
    assign win_l = {hi_word, lo_word, {WORD_W{1'b0}}};
    assign win_r = {fill, hi_word, lo_word};

    always_comb begin
        top_l = EXT_W - 1 - int'(eff);
        res_l = win_l[top_l -: WORD_W];   // R4: upper half after left shift
        res_r = win_r[int'(eff) +: WORD_W]; // R5/R6: lower half after right shift
        res   = dir_right ? res_r : res_l;
    end
endmodule

// File: rtl/fsh_out_stage.sv
module fsh_out_stage #(
    parameter int WORD_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] res_in,
    input  logic              ill_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_out,
    output logic              ill_out
);
    generate
        if (OUT_REG) begin : g_reg
            logic              valid_q;
            logic [WORD_W-1:0] res_q;
            logic              ill_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    res_q   <= '0;
                    ill_q   <= 1'b0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid) begin
                        res_q <= res_in;
                        ill_q <= ill_in;
                    end
                end
            end
            assign out_valid = valid_q;
            assign res_out   = res_q;
            assign ill_out   = ill_q;
        end else begin : g_pass
            assign out_valid = in_valid;
            assign res_out   = res_in;
            assign ill_out   = ill_in;
        end
    endgenerate
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
    import fsh_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int IMM_W   = 20,
    parameter bit OUT_REG = 1'b1,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int SH_W   = $clog2(PAIR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [WORD_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic              use_imm,
    input  logic              dir_right,
    input  logic [1:0]        max_mode,
    input  logic              wrap_en,
    input  logic [1:0]        ext_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              illegal
);
    lim_mode_e         mode;
    logic [SH_W-1:0]   eff;
    logic [WORD_W-1:0] core_res;
    logic [WORD_W-1:0] gated_res;
    logic              bad_op;

    assign mode = lim_mode_e'(max_mode);

    fsh_amount #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_amount (
        .amt_reg (amt_reg),
        .amt_imm (amt_imm),
        .use_imm (use_imm),
        .mode    (mode),
        .wrap_en (wrap_en),
        .eff     (eff)
    );

    fsh_core #(.WORD_W(WORD_W)) u_core (
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .eff       (eff),
        .dir_right (dir_right),
        .arith     (mode == LIM_W64S),
        .res       (core_res)
    );

    // R7/R8: unsupported encodings suppress the result
    assign bad_op    = (ext_mode != 2'd0) || (mode == LIM_RSVD);
    assign gated_res = bad_op ? '0 : core_res;

    fsh_out_stage #(.WORD_W(WORD_W), .OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .res_in    (gated_res),
        .ill_in    (bad_op),
        .out_valid (out_valid),
        .res_out   (result),
        .ill_out   (illegal)
    );

    generate
        if (OUT_REG) begin : g_chk
            logic armed;
            always_ff @(posedge clk) begin
                if (!rst_n) armed <= 1'b0;
                else        armed <= 1'b1;
            end

            a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                armed |-> (out_valid == $past(in_valid)));

            a_r7_ext_illegal: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && in_valid && ext_mode != 2'd0) |=> (illegal && result == '0));

            a_r8_rsvd_illegal: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && in_valid && max_mode == 2'd1) |=> (illegal && result == '0));

            a_r1_zero_left: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && in_valid && ext_mode == 2'd0 && max_mode != 2'd1 && !dir_right
                 && (use_imm ? (amt_imm == '0) : (amt_reg == '0)))
                |=> (result == $past(hi_word) && !illegal));

            a_r1_zero_right: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && in_valid && ext_mode == 2'd0 && max_mode != 2'd1 && dir_right
                 && (use_imm ? (amt_imm == '0) : (amt_reg == '0)))
                |=> (result == $past(lo_word) && !illegal));

            a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && in_valid && ext_mode == 2'd0 && max_mode == 2'd3 && dir_right
                 && !wrap_en && !use_imm && amt_reg >= WORD_W'(PAIR_W - 1))
                |=> (result == {WORD_W{$past(hi_word[WORD_W-1])}}));
        end
    endgenerate
endmodule

// File: tb/funnel_shift_unit_tb.sv
`timescale 1ns/1ps
module funnel_shift_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] lo_word, hi_word, amt_reg;
    logic [19:0] amt_imm;
    logic        use_imm, dir_right, wrap_en;
    logic [1:0]  max_mode, ext_mode;
    logic        out_valid, illegal;
    logic [31:0] result;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    funnel_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .lo_word(lo_word), .hi_word(hi_word), .amt_reg(amt_reg), .amt_imm(amt_imm),
        .use_imm(use_imm), .dir_right(dir_right), .max_mode(max_mode),
        .wrap_en(wrap_en), .ext_mode(ext_mode),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    function automatic logic [32:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [31:0] req, input logic rgt,
                                          input logic [1:0] m, input logic w,
                                          input logic [1:0] x);
        logic signed [63:0] p;
        logic [63:0]        t;
        int                 s;
        int                 lim;
        if (x != 2'd0 || m == 2'd1) return {1'b1, 32'h0};
        lim = (m == 2'd0) ? 32 : 63;
        if (w) s = (m == 2'd0) ? int'(req % 32) : int'(req % 64);
        else   s = (req > 32'(lim)) ? lim : int'(req);
        p = {hi, lo};
        if (!rgt)            begin t = p << s;  return {1'b0, t[63:32]}; end
        else if (m == 2'd3)  begin t = p >>> s; return {1'b0, t[31:0]};  end
        else                 begin t = p >> s;  return {1'b0, t[31:0]};  end
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual ill=%0b res=%08h expected ill=%0b res=%08h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] ar, input logic [19:0] ai, input logic ui,
                         input logic rgt, input logic [1:0] m, input logic w,
                         input logic [1:0] x);
        logic [31:0] req;
        @(negedge clk);
        lo_word = lo; hi_word = hi; amt_reg = ar; amt_imm = ai; use_imm = ui;
        dir_right = rgt; max_mode = m; wrap_en = w; ext_mode = x; in_valid = 1'b1;
        req = ui ? {12'h0, ai} : ar;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 valid"}, {32'h0, out_valid}, 33'h1);
        check(tag, {illegal, result}, model(lo, hi, req, rgt, m, w, x));
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [32:0] held;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; in_valid = 1'b0; lo_word = '0; hi_word = '0; amt_reg = '0;
        amt_imm = '0; use_imm = 1'b0; dir_right = 1'b0; max_mode = '0; wrap_en = 1'b0;
        ext_mode = '0;
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {out_valid, illegal, result[30:0]}, 33'h0);
        rst_n = 1'b1;

        // R1 zero shift
        apply("R1 left zero", 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 0, 2, 0, 0);
        apply("R1 right zero", 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 1, 3, 0, 0);
        // R2 clamp
        apply("R2 clamp32 left", 32'hCAFE_F00D, 32'h1111_2222, 100, 0, 0, 0, 0, 0, 0);
        apply("R2 clamp32 right", 32'hCAFE_F00D, 32'h1111_2222, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0);
        apply("R2 clamp63 left", 32'h8000_0001, 32'h0, 70, 0, 0, 0, 2, 0, 0);
        // R3 wrap
        apply("R3 wrap5", 32'hF0F0_1234, 32'hA5A5_5A5A, 36, 0, 0, 1, 0, 1, 0);
        apply("R3 wrap6", 32'hF0F0_1234, 32'hA5A5_5A5A, 68, 0, 0, 0, 2, 1, 0);
        // R4/R5
        apply("R4 left 8", 32'hAB00_0000, 32'h00CD_EF01, 8, 0, 0, 0, 2, 0, 0);
        apply("R5 right 4 logic", 32'h0000_0010, 32'hF000_0003, 4, 0, 0, 1, 2, 0, 0);
        // R6 arithmetic with clamp and with wrap on the same operation
        apply("R6 arith clamp", 32'h0, 32'h8000_0000, 200, 0, 0, 1, 3, 0, 0);
        apply("R6 arith wrap", 32'h0, 32'h8000_0000, 200, 0, 0, 1, 3, 1, 0);
        apply("R6 arith 40", 32'h1, 32'hC000_0000, 40, 0, 0, 1, 3, 0, 0);
        apply("R5 logic 40", 32'h1, 32'hC000_0000, 40, 0, 0, 1, 2, 0, 0);
        // R7/R8 illegal overrides a nonzero shift
        apply("R7 ext mode", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 0, 0, 0, 2, 0, 2);
        apply("R8 reserved mode", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 0, 0, 1, 1, 0, 0);
        // R10 immediate source
        apply("R10 imm", 32'h0, 32'h0000_00FF, 32'h0, 20'd4, 1, 0, 0, 0, 0);
        apply("R10 imm clamp", 32'h5555_0000, 32'h0, 32'h1, 20'hFFFFF, 1, 1, 2, 0, 0);

        // R9 hold while in_valid is low
        held = {illegal, result};
        @(negedge clk);
        lo_word = 32'hDEAD_BEEF; hi_word = 32'h1357_9BDF; amt_reg = 5; max_mode = 2;
        ext_mode = 3;
        repeat (2) @(negedge clk);
        check("R9 hold result", {illegal, result}, held);
        check("R9 hold valid", {32'h0, out_valid}, 33'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ar;
            logic [1:0]  m, x;
            int          pick;
            pick = int'($urandom % 4);
            ar = (pick == 0) ? $urandom : (pick == 1) ? 32'($urandom % 70) : 32'($urandom % 33);
            m  = 2'($urandom);
            x  = ($urandom % 10 == 0) ? 2'($urandom % 3 + 1) : 2'd0;
            apply("R4/R5/R6 random", $urandom, $urandom, ar, 20'($urandom % 80),
                  1'($urandom), 1'($urandom), m, 1'($urandom), x);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule